// File: doc/BRIEF.md
# Circular-Buffer Sample Delay Line

This block delays a continuous stream of 16-bit converter samples by a programmable number of sample periods. On every clock it stores the incoming sample into a ring of memory locations and fetches one older sample for the output. No trigger, capture window or countdown is involved. The delay comes only from the distance, counted in locations, between the address being written and the address being read. At a 100 MHz sample rate, each location of distance adds 10 ns of echo delay, which is 1.5 m of apparent range.

The write address steps by one on every clock and wraps from the last location back to zero, so the oldest sample is overwritten. That sample is no longer needed once it is older than the longest delay the ring can hold. The delay value is loaded with a strobe and used from the following clock. Values that do not fit in the ring are clamped to the largest usable delay, and a flag reports that clamping took place. The depth is a power of two set by an address-width parameter. A ring for a 100 km target (about 66,700 samples) needs an address width of 17. The default is kept small.

Top module: `drfm_delay_line`

## Requirements
- R1: When the active delay is d, the `dac_sample` visible after clock edge k equals the `adc_sample` captured at edge k-d-1, as long as `dac_valid` is high.
- R2: The ring has 2^ADDR_W locations. Both addresses wrap modulo that depth, and R1 continues to hold after any number of wraps.
- R3: `delay_in` is taken only on an edge where `delay_load` is 1, and it governs reads from the next edge on. While `delay_load` is 0, changes on `delay_in` have no effect on the output.
- R4: A loaded `delay_in` greater than 2^ADDR_W-1 is clamped to 2^ADDR_W-1, and `delay_clipped` goes to 1. The next in-range load clears `delay_clipped` to 0.
- R5: After reset, `dac_valid` stays 0 until at least d+1 samples have been written. While `dac_valid` is 0, `dac_sample` is 0.
- R6: Reset is synchronous and active high. It leaves `dac_valid` at 0, `dac_sample` at 0, `delay_clipped` at 0 and the active delay at 0.
- R7: The memory read costs exactly one cycle. With delay 0, the output repeats the input one clock later.
- R8: At the largest delay, 2^ADDR_W-1, the output is the sample captured 2^ADDR_W edges earlier. This is the oldest sample still present in the ring.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| adc_sample | input | 16 | Incoming converter sample, one per clock |
| delay_in | input | DLY_W | Requested delay in samples |
| delay_load | input | 1 | Strobe that loads `delay_in` |
| dac_sample | output | 16 | Delayed sample for the output converter |
| dac_valid | output | 1 | High when `dac_sample` holds a sample written since reset |
| delay_clipped | output | 1 | The last loaded delay was clamped |

## Verification
The embedded assertions watch the write address step by one each clock, with wrap included. They also check that the active delay holds between strobes, that the clamp flag rises only after a load, and that the output is invalid on the first cycle after reset. Sample-accurate delay against the input history cannot be checked by a property. Neither can correct data across many wraps, clamped maximum-depth delay or the ignored-input behaviour. Only the bench's reference model can show these, and it compares every output cycle under directed and random delay changes.

// File: rtl/drfm_pkg.sv
`timescale 1ns/1ps
package drfm_pkg;
    localparam int unsigned SAMPLE_W = 16;

    typedef logic [SAMPLE_W-1:0] sample_t;

    typedef struct packed {
        sample_t data;
        logic    valid;
    } tap_t;

    // Number of ring locations for a given address width.
    function automatic int unsigned ring_depth(input int unsigned aw);
        return 32'd1 << aw;
    endfunction
endpackage

// File: rtl/drfm_delay_ctrl.sv
`timescale 1ns/1ps
module drfm_delay_ctrl import drfm_pkg::*; #(
    parameter int unsigned ADDR_W = 10,
    parameter int unsigned DLY_W  = ADDR_W + 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [DLY_W-1:0]  delay_in,
    output logic [ADDR_W-1:0] dly,
    output logic              clip
);
    localparam int unsigned    DEPTH = ring_depth(ADDR_W);
    localparam logic [DLY_W-1:0] MAX_DLY = DLY_W'(DEPTH - 1);

    logic              over;
    logic [ADDR_W-1:0] sat;
    logic [ADDR_W-1:0] dly_q;
    logic              clip_q;

    always_comb begin
        over = (delay_in > MAX_DLY);
        sat  = over ? MAX_DLY[ADDR_W-1:0] : delay_in[ADDR_W-1:0];
    end

    // New delay takes effect on a clock boundary only, never mid-cycle.
    always_ff @(posedge clk) begin
        if (rst) begin
            dly_q  <= '0;
            clip_q <= 1'b0;
        end else if (load) begin
            dly_q  <= sat;
            clip_q <= over;
        end
    end

    assign dly  = dly_q;
    assign clip = clip_q;

    // R3: without a strobe the active delay does not move
    a_r3_delay_hold: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(dly_q));

    // R4: clamp flag can only appear as a result of a load
    a_r4_clip_after_load: assert property (@(posedge clk) disable iff (rst)
        $rose(clip_q) |-> $past(load));
endmodule

// File: rtl/drfm_ptr_gen.sv
`timescale 1ns/1ps
module drfm_ptr_gen import drfm_pkg::*; #(
    parameter int unsigned ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] dly,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              rd_ok
);
    localparam int unsigned     DEPTH  = ring_depth(ADDR_W);
    localparam int unsigned     FILL_W = ADDR_W + 1;
    localparam logic [FILL_W-1:0] FULL = FILL_W'(DEPTH);

    logic [ADDR_W-1:0] wp_q;
    logic [FILL_W-1:0] fill_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            wp_q   <= '0;
            fill_q <= '0;
        end else begin
            wp_q <= wp_q + 1'b1;
            if (fill_q != FULL)
                fill_q <= fill_q + 1'b1;
        end
    end

    // Read one slot further back than the delay: the read itself adds a cycle.
    always_comb begin
        wr_addr = wp_q;
        rd_addr = wp_q - dly - 1'b1;
        rd_ok   = (fill_q > {1'b0, dly});
    end

    // R2: write address advances by one per clock, wrapping modulo depth
    a_r2_ptr_step: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> wp_q == ADDR_W'($past(wp_q) + 1'b1));

    // R5: fill count never passes the ring depth
    a_r5_fill_cap: assert property (@(posedge clk) disable iff (rst)
        fill_q <= FULL);
endmodule

// File: rtl/drfm_sample_ram.sv
`timescale 1ns/1ps
module drfm_sample_ram import drfm_pkg::*; #(
    parameter int unsigned ADDR_W = 10
) (
    input  logic              clk,
    input  logic [ADDR_W-1:0] wr_addr,
    input  sample_t           wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output sample_t           rd_data
);
    localparam int unsigned DEPTH = ring_depth(ADDR_W);

    sample_t mem [DEPTH];
    sample_t rd_q;

    // Read-before-write on a shared address returns the old word.
    always_ff @(posedge clk) begin
        mem[wr_addr] <= wr_data;
        rd_q         <= mem[rd_addr];
    end

    assign rd_data = rd_q;
endmodule

// File: rtl/drfm_delay_line.sv
`timescale 1ns/1ps
module drfm_delay_line import drfm_pkg::*; #(
    parameter int unsigned ADDR_W = 10,
    parameter int unsigned DLY_W  = ADDR_W + 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [SAMPLE_W-1:0] adc_sample,
    input  logic [DLY_W-1:0]    delay_in,
    input  logic                delay_load,
    output logic [SAMPLE_W-1:0] dac_sample,
    output logic                dac_valid,
    output logic                delay_clipped
);
    logic [ADDR_W-1:0] dly;
    logic [ADDR_W-1:0] wr_addr;
    logic [ADDR_W-1:0] rd_addr;
    logic              rd_ok;
    sample_t           ram_q;
    tap_t              tap;
    logic              valid_q;

    drfm_delay_ctrl #(.ADDR_W(ADDR_W), .DLY_W(DLY_W)) ctrl_i (
        .clk(clk), .rst(rst), .load(delay_load), .delay_in(delay_in),
        .dly(dly), .clip(delay_clipped)
    );

    drfm_ptr_gen #(.ADDR_W(ADDR_W)) ptr_i (
        .clk(clk), .rst(rst), .dly(dly),
        .wr_addr(wr_addr), .rd_addr(rd_addr), .rd_ok(rd_ok)
    );

    drfm_sample_ram #(.ADDR_W(ADDR_W)) ram_i (
        .clk(clk), .wr_addr(wr_addr), .wr_data(adc_sample),
        .rd_addr(rd_addr), .rd_data(ram_q)
    );

    // Valid flag follows the one-cycle memory latency.
    always_ff @(posedge clk) begin
        if (rst) valid_q <= 1'b0;
        else     valid_q <= rd_ok;
    end

    always_comb begin
        tap.valid = valid_q;
        tap.data  = valid_q ? ram_q : '0;
    end

    assign dac_sample = tap.data;
    assign dac_valid  = tap.valid;

    // R5: nothing valid on the first cycle after reset
    a_r5_first_cycle_idle: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !dac_valid);
endmodule

// File: tb/drfm_delay_line_tb_top.sv
`timescale 1ns/1ps
module drfm_delay_line_tb_top;
    localparam int unsigned AW = 6;
    localparam int unsigned DW = AW + 2;
    localparam int          D  = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [15:0]   adc = '0;
    logic [DW-1:0] din = '0;
    logic          dload = 1'b0;
    logic [15:0]   dac;
    logic          dvalid;
    logic          dclip;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic [15:0] hist [0:4095];
    int k;
    int m_d;
    bit m_clip;

    always #2 clk = ~clk;

    drfm_delay_line #(.ADDR_W(AW), .DLY_W(DW)) dut_i (
        .clk(clk), .rst(rst), .adc_sample(adc), .delay_in(din),
        .delay_load(dload), .dac_sample(dac), .dac_valid(dvalid),
        .delay_clipped(dclip)
    );

    task automatic chk(input string req, input string what,
                       input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d (k=%0d)",
                     req, what, act, exp, k);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1; dload = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        k = 0; m_d = 0; m_clip = 1'b0;
        chk("R6", "valid", int'(dvalid), 0);
        chk("R6", "sample", int'(dac), 0);
        chk("R6", "clip", int'(dclip), 0);
    endtask

    task automatic tick(input logic [15:0] s, input bit ld,
                        input logic [DW-1:0] dv, input string req);
        bit exp_v;
        int exp_s;
        adc = s; dload = ld; din = dv;
        @(posedge clk);
        exp_v = (k >= m_d + 1);
        exp_s = exp_v ? int'(hist[k - m_d - 1]) : 0;
        hist[k] = s;
        k++;
        if (ld) begin
            m_clip = (int'(dv) > D - 1);
            m_d    = m_clip ? D - 1 : int'(dv);
        end
        @(negedge clk);
        dload = 1'b0;
        chk(req, "valid", int'(dvalid), int'(exp_v));
        chk(req, "sample", int'(dac), exp_s);
        chk(req, "clip", int'(dclip), int'(m_clip));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'd2024);
        do_reset();
        // R7: delay 0 gives one-cycle echo; R5 valid after first write
        for (int i = 0; i < 12; i++) tick(16'(1000 + i), 1'b0, '0, "R7");
        // R3: load delay 3
        tick(16'h0A0A, 1'b1, DW'(3), "R3");
        for (int i = 0; i < 20; i++) tick(16'($urandom), 1'b0, '0, "R3");
        // R3: delay_in wiggles with no strobe, no effect
        for (int i = 0; i < 20; i++) tick(16'($urandom), 1'b0, DW'($urandom), "R3");
        // R4/R8: over-range clamps to D-1, oldest sample returned
        tick(16'h1234, 1'b1, DW'(D + 37), "R4");
        for (int i = 0; i < 3 * D; i++) tick(16'($urandom), 1'b0, '0, "R8");
        // R4: in-range load clears flag
        tick(16'h5555, 1'b1, DW'(10), "R4");
        for (int i = 0; i < 15; i++) tick(16'($urandom), 1'b0, '0, "R4");
        // R4: exact boundary D-1 is not clamped
        tick(16'h7777, 1'b1, DW'(D - 1), "R4");
        for (int i = 0; i < D + 4; i++) tick(16'($urandom), 1'b0, '0, "R8");
        // R1/R2: random delays across many wraps
        for (int i = 0; i < 2000; i++) begin
            bit ld;
            ld = ($urandom % 40) == 0;
            tick(16'($urandom), ld, DW'($urandom % (D + 24)), (i % 2) ? "R1" : "R2");
        end
        // R5: reset mid-run, long delay, valid waits for fill
        do_reset();
        tick(16'h0001, 1'b1, DW'(20), "R5");
        for (int i = 0; i < 40; i++) tick(16'(i + 2), 1'b0, '0, "R5");
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule